// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block makes the timing for a buffered audio serial port. A divider, clocked by a functional clock, produces a square bit clock. The frame sequencer steps once per bit. It produces a frame-sync pulse with a programmable period and a programmable active width. The frame sync can be produced in two ways: periodically from a frame counter, or once for each data-register write strobe. The transmit and receive sides each get their own bit clock and frame sync, and each of those four outputs has its own polarity.

Software writes one 32-bit generator word, and two plain enables gate the work. The divider enable runs the bit clock. The frame enable runs the frame sequencer. A write is held in a pending copy. It is moved to the active copy while the frame sequencer is idle. While a frame is running, it is moved only at the next frame boundary, so a change cannot cut a pulse or a bit short. The block has no data path, so no valid/ready handshake is involved.

Top module: `audio_sync_gen`

## Requirements
- R1: After reset, with all polarity bits clear and both enables low, all four outputs are low.
- R2: Generator word bits 7:0 hold a divider value D. While the divider enable is high, the uninverted bit clock is a square wave whose high and low phases each last D+1 functional clock cycles, so one bit lasts 2(D+1) cycles.
- R3: Generator word bits 15:8 hold W. Each frame-sync pulse stays active for W+1 bits.
- R4: When generator word bit 28 is 1 (periodic mode), the frame sync repeats. Generator word bits 27:16 hold P, and consecutive pulses start P+1 bits apart.
- R5: Every change of the uninverted frame sync happens at the same functional clock edge at which the uninverted bit clock falls.
- R6: While the divider enable is low, the uninverted bit clock is held low and the frame sync holds its value.
- R7: While the frame enable is low, the uninverted frame sync is low from the next edge on, and the bit clock keeps running.
- R8: After the frame enable rises, the first frame-sync pulse starts at the first bit-clock fall.
- R9: Polarity input bit 0 inverts the transmit bit clock, bit 1 the receive bit clock, bit 2 the transmit frame sync and bit 3 the receive frame sync. The inversion takes effect in the same cycle.
- R10: When bit 28 is 0 (triggered mode), no pulse occurs without a data-write strobe. Each strobe produces exactly one pulse of W+1 bits, which starts at a later bit-clock fall.
- R11: A generator word written while a periodic frame is running has no effect on that frame. It takes effect from the next frame boundary.
- R12: With P = 2N-1 and W = N-1, the frame sync has a 50% duty cycle: high and low each last N bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the generator word |
| cfg_data_i | input | 32 | Generator word: [7:0] divider, [15:8] width-1, [27:16] period-1, [28] periodic mode |
| pol_i | input | 4 | Inversion bits: [0] tx clock, [1] rx clock, [2] tx frame sync, [3] rx frame sync |
| div_en_i | input | 1 | Runs the bit-clock divider |
| fs_en_i | input | 1 | Runs the frame sequencer |
| data_wr_i | input | 1 | Data-register write strobe, triggers a pulse in triggered mode |
| bclk_tx_o | output | 1 | Transmit bit clock |
| bclk_rx_o | output | 1 | Receive bit clock |
| fs_tx_o | output | 1 | Transmit frame sync |
| fs_rx_o | output | 1 | Receive frame sync |

## Verification
The bit clock and the frame sync both come from registers. They change at the edge on which the divider count reaches its limit. Polarity is applied combinationally, so it takes effect in the same cycle. A generator word written while the sequencer is idle becomes active two edges after the strobe. A word written during a running frame waits for the frame boundary. The bench drives inputs and samples outputs on falling edges. It measures durations by counting cycles between observed output transitions, never from a fixed delay after the stimulus. This keeps every check independent of pipeline depth, while still pinning the first pulse to the first bit-clock fall and pinning each frame-sync change to the falling edge of the bit clock.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int DIV_W    = 8;
  localparam int WID_W    = 8;
  localparam int PER_W    = 12;
  localparam int CFG_W    = 32;
  localparam int DIV_LSB  = 0;
  localparam int WID_LSB  = 8;
  localparam int PER_LSB  = 16;
  localparam int MODE_BIT = 28;
  localparam int N_SIDES  = 2;   // transmit, receive

  typedef struct packed {
    logic             periodic;
    logic [PER_W-1:0] period;
    logic [WID_W-1:0] width;
    logic [DIV_W-1:0] div;
  } gen_cfg_t;

  // Power-up setting: symmetric 16-bit stereo frame, no division.
  localparam gen_cfg_t CFG_RESET = '{periodic: 1'b1, period: PER_W'(31),
                                     width: WID_W'(15), div: '0};

  function automatic gen_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    gen_cfg_t c;
    c.div      = w[DIV_LSB +: DIV_W];
    c.width    = w[WID_LSB +: WID_W];
    c.period   = w[PER_LSB +: PER_W];
    c.periodic = w[MODE_BIT];
    return c;
  endfunction
endpackage

// File: rtl/afs_cfg_shadow.sv
module afs_cfg_shadow
  import afs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             load_i,
  output gen_cfg_t         act_o
);
  gen_cfg_t pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= CFG_RESET;
      act_q  <= CFG_RESET;
    end else begin
      if (wr_i)   pend_q <= unpack_cfg(wdata_i);
      if (load_i) act_q  <= pend_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/afs_bclk_div.sv
module afs_bclk_div
  import afs_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         phase_o,
  output logic         fall_tick_o
);
  logic [W-1:0] cnt_q;
  logic         phase_q;
  logic         tick;

  assign tick = en_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o     = phase_q;
  assign fall_tick_o = tick && phase_q;

  // R6
  div_hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !phase_q);

  // R2
  div_phase_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q < div_i) |=> $stable(phase_q));
endmodule

// File: rtl/afs_frame_seq.sv
module afs_frame_seq
  import afs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     fall_tick_i,
  input  logic     data_wr_i,
  input  gen_cfg_t cfg_i,
  output logic     fs_o,
  output logic     run_o,
  output logic     boundary_o
);
  logic [PER_W-1:0] pos_q, pos_inc, width_ext;
  logic             run_q, fs_q, armed_q;

  assign pos_inc   = pos_q + 1'b1;
  assign width_ext = PER_W'(cfg_i.width);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      run_q   <= 1'b0;
      fs_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      pos_q   <= '0;
      run_q   <= 1'b0;
      fs_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (fall_tick_i) begin
        if (cfg_i.periodic) begin
          if (!run_q || pos_q == cfg_i.period) begin
            run_q <= 1'b1;
            pos_q <= '0;
            fs_q  <= 1'b1;
          end else begin
            pos_q <= pos_inc;
            fs_q  <= (pos_inc <= width_ext);
          end
        end else if (armed_q) begin
          armed_q <= 1'b0;
          run_q   <= 1'b1;
          pos_q   <= '0;
          fs_q    <= 1'b1;
        end else if (run_q) begin
          if (pos_inc <= width_ext) begin
            pos_q <= pos_inc;
            fs_q  <= 1'b1;
          end else begin
            run_q <= 1'b0;
            pos_q <= '0;
            fs_q  <= 1'b0;
          end
        end
      end
      if (data_wr_i && !cfg_i.periodic) armed_q <= 1'b1;
    end
  end

  assign fs_o       = fs_q;
  assign run_o      = run_q;
  assign boundary_o = en_i && fall_tick_i && cfg_i.periodic && run_q &&
                      (pos_q == cfg_i.period);

  // R7
  fs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fs_q);

  // R5
  fs_edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fall_tick_i) |=> $stable(fs_q));

  // R8
  fs_first_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fall_tick_i && cfg_i.periodic && !run_q) |=> fs_q);
endmodule

// File: rtl/audio_sync_gen.sv
module audio_sync_gen
  import afs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_i,
  input  logic [31:0] cfg_data_i,
  input  logic [3:0]  pol_i,
  input  logic        div_en_i,
  input  logic        fs_en_i,
  input  logic        data_wr_i,
  output logic        bclk_tx_o,
  output logic        bclk_rx_o,
  output logic        fs_tx_o,
  output logic        fs_rx_o
);
  gen_cfg_t           act;
  logic               phase, fall_tick, fs_raw, run, boundary, load;
  logic [N_SIDES-1:0] bclk_side, fs_side;

  assign load = !run || boundary;

  afs_cfg_shadow u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_data_i),
    .load_i  (load),
    .act_o   (act)
  );

  afs_bclk_div #(.W(DIV_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (div_en_i),
    .div_i       (act.div),
    .phase_o     (phase),
    .fall_tick_o (fall_tick)
  );

  afs_frame_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (fs_en_i),
    .fall_tick_i (fall_tick),
    .data_wr_i   (data_wr_i),
    .cfg_i       (act),
    .fs_o        (fs_raw),
    .run_o       (run),
    .boundary_o  (boundary)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    assign bclk_side[s] = phase  ^ pol_i[s];
    assign fs_side[s]   = fs_raw ^ pol_i[N_SIDES + s];
  end

  assign bclk_tx_o = bclk_side[0];
  assign bclk_rx_o = bclk_side[1];
  assign fs_tx_o   = fs_side[0];
  assign fs_rx_o   = fs_side[1];

  // R11
  cfg_frozen_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !boundary) |=> $stable(act));
endmodule

// File: tb/tb_audio_sync_gen.sv
module tb_audio_sync_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [31:0] cfg_data_i = '0;
  logic [3:0]  pol_i = '0;
  logic        div_en_i = 1'b0;
  logic        fs_en_i = 1'b0;
  logic        data_wr_i = 1'b0;
  logic        bclk_tx_o, bclk_rx_o, fs_tx_o, fs_rx_o;

  int checks = 0;
  int errors = 0;
  localparam int LIM = 4000;

  // {divider, width-1, period-1}
  localparam logic [27:0] VEC [4] = '{
    {8'd0, 8'd15, 12'd31},
    {8'd1, 8'd3,  12'd7},
    {8'd2, 8'd0,  12'd33},
    {8'd3, 8'd7,  12'd40}
  };

  always #2.5 clk = ~clk;

  audio_sync_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .pol_i(pol_i), .div_en_i(div_en_i), .fs_en_i(fs_en_i), .data_wr_i(data_wr_i),
    .bclk_tx_o(bclk_tx_o), .bclk_rx_o(bclk_rx_o), .fs_tx_o(fs_tx_o), .fs_rx_o(fs_rx_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic periodic, input logic [7:0] d,
                                       input logic [7:0] w, input logic [11:0] p);
    return {3'b000, periodic, p, w, d};
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    cfg_data_i = w;
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  // Waits for a rising frame sync; returns cycles waited and whether the
  // bit clock fell on that same sample.
  task automatic wait_fs_rise(output int cyc, output int aligned);
    logic pf, pb;
    cyc = 0;
    do begin
      pf = fs_tx_o; pb = bclk_tx_o;
      @(negedge clk);
      cyc++;
    end while (!(fs_tx_o && !pf) && cyc < LIM);
    aligned = (pb && !bclk_tx_o) ? 1 : 0;
  endtask

  // Called on the sample where the pulse rose; measures high and period.
  task automatic frame_measure(input bit do_wr, input logic [31:0] w,
                               output int hi, output int per);
    int lo, al;
    hi = 0;
    if (do_wr) begin
      write_cfg(w);
      hi = 1;
    end
    while (fs_tx_o && hi < LIM) begin
      @(negedge clk);
      hi++;
    end
    wait_fs_rise(lo, al);
    per = hi + lo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, per, cyc, al, n, falls, toggles;
    logic pb, pf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bclk_tx", bclk_tx_o, 0);
    check("R1 bclk_rx", bclk_rx_o, 0);
    check("R1 fs_tx", fs_tx_o, 0);
    check("R1 fs_rx", fs_rx_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {bclk_tx_o, bclk_rx_o, fs_tx_o, fs_rx_o}, 0);

    for (int i = 0; i < 4; i++) begin
      int d, w, p, bit_c;
      d = int'(VEC[i][27:20]); w = int'(VEC[i][19:12]); p = int'(VEC[i][11:0]);
      bit_c = 2 * (d + 1);
      div_en_i = 1'b0; fs_en_i = 1'b0;
      @(negedge clk);
      write_cfg(word(1'b1, VEC[i][27:20], VEC[i][19:12], VEC[i][11:0]));
      repeat (3) @(negedge clk);
      div_en_i = 1'b1;
      // R2 half period
      n = 0;
      do begin pb = bclk_tx_o; @(negedge clk); n++; end
      while (!(bclk_tx_o && !pb) && n < LIM);
      hi = 0;
      while (bclk_tx_o && hi < LIM) begin @(negedge clk); hi++; end
      check($sformatf("R2 half period vec%0d", i), hi, d + 1);
      // R8 first pulse on first bit-clock fall
      fs_en_i = 1'b1;
      falls = 0; n = 0; pb = bclk_tx_o;
      while (!fs_tx_o && n < LIM) begin
        @(negedge clk); n++;
        if (pb && !bclk_tx_o) falls++;
        pb = bclk_tx_o;
      end
      check($sformatf("R8 falls before pulse vec%0d", i), falls, 1);
      frame_measure(1'b0, '0, hi, per);
      check($sformatf("R3 pulse width vec%0d", i), hi, (w + 1) * bit_c);
      check($sformatf("R4 frame period vec%0d", i), per, (p + 1) * bit_c);
      wait_fs_rise(cyc, al);
      check($sformatf("R5 edge alignment vec%0d", i), al, 1);
      check($sformatf("R3 rx copy vec%0d", i), fs_rx_o, 1);
      if (i == 0) check("R12 symmetric duty", hi, per - hi);
    end

    // R11 mid-frame rewrite waits for the frame boundary
    div_en_i = 1'b0; fs_en_i = 1'b0;
    @(negedge clk);
    write_cfg(word(1'b1, 8'd1, 8'd3, 12'd7));
    repeat (3) @(negedge clk);
    div_en_i = 1'b1; fs_en_i = 1'b1;
    wait_fs_rise(cyc, al);
    frame_measure(1'b1, word(1'b1, 8'd1, 8'd3, 12'd15), hi, per);
    check("R11 current frame keeps old period", per, 32);
    frame_measure(1'b0, '0, hi, per);
    check("R11 next frame uses new period", per, 64);
    check("R11 width unchanged", hi, 16);

    // R6 divider off freezes bit clock low and holds frame sync
    @(negedge clk);
    div_en_i = 1'b0;
    repeat (2) @(negedge clk);
    pf = fs_tx_o; toggles = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bclk_tx_o) toggles++;
      if (fs_tx_o != pf) toggles++;
    end
    check("R6 bclk low and fs held", toggles, 0);

    // R7 frame enable off: fs low, bit clock runs
    div_en_i = 1'b1; fs_en_i = 1'b0;
    @(negedge clk);
    toggles = 0; n = 0; pb = bclk_tx_o;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (fs_tx_o) n++;
      if (bclk_tx_o != pb) toggles++;
      pb = bclk_tx_o;
    end
    check("R7 fs stays low", n, 0);
    check("R7 bclk toggles", (toggles > 0) ? 1 : 0, 1);

    // R10 triggered mode
    div_en_i = 1'b0;
    @(negedge clk);
    write_cfg(word(1'b0, 8'd1, 8'd2, 12'd7));
    repeat (3) @(negedge clk);
    div_en_i = 1'b1; fs_en_i = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (fs_tx_o) n++; end
    check("R10 no pulse without strobe", n, 0);
    data_wr_i = 1'b1;
    @(negedge clk);
    data_wr_i = 1'b0;
    wait_fs_rise(cyc, al);
    check("R10 pulse after strobe", fs_tx_o, 1);
    hi = 0;
    while (fs_tx_o && hi < LIM) begin @(negedge clk); hi++; end
    check("R10 pulse width", hi, 12);
    n = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (fs_tx_o) n++; end
    check("R10 single pulse only", n, 0);

    // R9 polarity
    div_en_i = 1'b0; fs_en_i = 1'b0;
    repeat (2) @(negedge clk);
    pol_i = 4'b0101;
    #1;
    check("R9 pol 0101", {bclk_tx_o, bclk_rx_o, fs_tx_o, fs_rx_o}, 4'b1010);
    pol_i = 4'b1010;
    #1;
    check("R9 pol 1010", {bclk_tx_o, bclk_rx_o, fs_tx_o, fs_rx_o}, 4'b0101);
    pol_i = 4'b0000;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule